// File: doc/BRIEF.md
# Microprogram Sequencer with Decode Flags

This block steers a microcoded datapath. Every macroinstruction begins with a decode step. The 16-bit word at the head of the instruction queue indexes a starting decode table. That table returns a 24-bit microinstruction, which is issued at once, and a 16-bit sequencing instruction. In the same step a flag decode table loads four microcode-visible flags from the word. Several macroinstructions can share one starting entry, and these flags tell them apart.

After the decode, the sequencing instruction either asks for the next decode or sends the sequencer into the control store. In the control store a microprogram counter and a small decision stage pick each next address. Each control store word carries its own microinstruction and its own sequencing instruction. The walk goes on until a word asks for a decode. Microcode can test a flag through a conditional jump and can write any single flag.

Two streams meet at the block. The instruction queue feeds words in over a valid/ready pair, and a pop is the cycle in which both are high. Microinstructions leave over a valid/ready pair as well. A consumer that holds `uop_ready` low freezes the sequencer, with the current beat held unchanged. While the block is in the decode step, `iq_ready` is high only when `uop_ready` is high. A word is therefore taken from the queue exactly when its first microinstruction is accepted.

Top module: `microseq_top`

## Requirements
- R1: After reset the sequencer is in the decode step: all four flags read 0, `uaddr` is 0, `uop_valid` is low while the queue is empty, and `iq_ready` equals `uop_ready`.
- R2: In the decode step with `iq_valid` low, `uop_valid` stays low and the flags and `uaddr` do not change.
- R3: A queue pop (`iq_valid` and `iq_ready` both high) happens only in the decode step, in the same cycle that the starting microinstruction is accepted. That microinstruction is {4'hA, word[15:12], word[15:0]}. `iq_ready` is low in every control store beat.
- R4: At decode the flags load from the head word. Flag bit i takes word bit i (i = 0..3), except that words whose top nibble is 0 clear all flags.
- R5: A sequencing instruction is laid out as op [15:13], flag select [12:11], flag value [10] and target address [9:0], of which the low ADDR_W bits are used. The op codes are 0 = next, 1 = jump, 2 = jump if flag, 3 = set flag and 4 = end. Codes 5 to 7 act as end.
- R6: "Next" moves to the current address plus one. "Jump" moves to the target address.
- R7: "Jump if flag" moves to the target when flag[select] equals the value bit, and otherwise to the current address plus one. In the decode step the test uses the freshly decoded flags.
- R8: "Set flag" writes the value bit into flag[select], leaves the other three flags unchanged, and moves to the current address plus one.
- R9: "End" returns the sequencer to the decode step, with `uaddr` at 0, after the beat that carries it is accepted.
- R10: While `uop_valid` is high and `uop_ready` is low, `uop_data`, `uop_valid`, `uaddr` and the flags hold their values.
- R11: For a decode-step sequencing instruction the current address counts as 0, so "next" from a starting entry goes to control store address 1.
- R12: A control store beat issues `uop_data` = 24'hC00000 with its low bits equal to the address, and `uaddr` shows that address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| iq_word | input | 16 | Head word of the instruction queue |
| iq_valid | input | 1 | Queue holds a word |
| iq_ready | output | 1 | Sequencer takes the head word this cycle if valid |
| uop_data | output | 24 | Microinstruction being issued |
| uop_valid | output | 1 | `uop_data` carries a beat |
| uop_ready | input | 1 | Consumer accepts the beat |
| uaddr | output | ADDR_W | Current control store address, 0 during decode |
| flags | output | 4 | The four microcode flags |

## Verification
A wrong next-address decision shows up in the very next accepted beat: the low bits of `uop_data` and `uaddr` name the wrong control store word, and the beat count of the instruction changes. A lost or wrongly loaded flag changes the branch taken one beat after the test, and it remains visible on `flags` once the instruction ends. A state register stuck in the wrong step shows at once, either as a missing pop when the first beat is accepted or as `uop_valid` rising with an empty queue.

// File: rtl/useq_pkg.sv
package useq_pkg;
  localparam int IQ_W  = 16;
  localparam int UI_W  = 24;
  localparam int NFLAG = 4;
  localparam int TGT_W = 10;

  typedef enum logic [2:0] {
    SQ_NEXT  = 3'd0,
    SQ_JUMP  = 3'd1,
    SQ_JFLAG = 3'd2,
    SQ_SETF  = 3'd3,
    SQ_END   = 3'd4
  } sq_op_e;

  typedef struct packed {
    logic [2:0]       op;
    logic [1:0]       sel;
    logic             val;
    logic [TGT_W-1:0] tgt;
  } seq_t;

  typedef enum logic {ST_DECODE = 1'b0, ST_RUN = 1'b1} st_e;

  function automatic seq_t mk_seq(sq_op_e op, logic [1:0] sel, logic val,
                                  logic [TGT_W-1:0] tgt);
    seq_t s;
    s.op  = op;
    s.sel = sel;
    s.val = val;
    s.tgt = tgt;
    return s;
  endfunction
endpackage

// File: rtl/useq_start_dec.sv
module useq_start_dec
  import useq_pkg::*;
(
  input  logic [IQ_W-1:0]  word,
  output logic [UI_W-1:0]  uinstr,
  output seq_t             seq,
  output logic [NFLAG-1:0] init_flags
);
  logic [3:0] key;
  assign key    = word[IQ_W-1:IQ_W-4];
  assign uinstr = {4'hA, key, word};

  // starting entries: one per opcode nibble, several words share each
  always_comb begin
    unique case (key)
      4'h1:    seq = mk_seq(SQ_JUMP,  2'd0, 1'b0, 10'h010);
      4'h2:    seq = mk_seq(SQ_JFLAG, 2'd0, 1'b1, 10'h020);
      4'h3:    seq = mk_seq(SQ_NEXT,  2'd0, 1'b0, 10'h000);
      4'h4:    seq = '{op: 3'd7, sel: 2'd0, val: 1'b0, tgt: '0};
      default: seq = mk_seq(SQ_END,   2'd0, 1'b0, 10'h000);
    endcase
  end

  // flag decode: low nibble tells apart words sharing an entry
  always_comb begin
    if (key == 4'h0) init_flags = '0;
    else             init_flags = word[NFLAG-1:0];
  end
endmodule

// File: rtl/useq_cstore.sv
module useq_cstore
  import useq_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [UI_W-1:0]   uinstr,
  output seq_t              seq
);
  localparam int PAD_W = UI_W - 8 - ADDR_W;

  assign uinstr = {8'hC0, {PAD_W{1'b0}}, addr};

  always_comb begin
    case (int'(addr))
      1:       seq = mk_seq(SQ_SETF,  2'd2, 1'b1, 10'h000);
      2:       seq = mk_seq(SQ_JFLAG, 2'd2, 1'b1, 10'h018);
      16:      seq = mk_seq(SQ_NEXT,  2'd0, 1'b0, 10'h000);
      24:      seq = mk_seq(SQ_JFLAG, 2'd1, 1'b0, 10'h011);
      32:      seq = mk_seq(SQ_SETF,  2'd3, 1'b0, 10'h000);
      default: seq = mk_seq(SQ_END,   2'd0, 1'b0, 10'h000);
    endcase
  end
endmodule

// File: rtl/useq_next_addr.sv
module useq_next_addr
  import useq_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  seq_t              seq,
  input  logic [ADDR_W-1:0] pc,
  input  logic [NFLAG-1:0]  flags_in,
  output logic [ADDR_W-1:0] next_pc,
  output logic              to_decode,
  output logic              set_en,
  output logic [1:0]        set_sel,
  output logic              set_val
);
  logic [ADDR_W-1:0] tgt;
  logic [ADDR_W-1:0] inc;
  assign tgt     = seq.tgt[ADDR_W-1:0];
  assign inc     = pc + 1'b1;
  assign set_sel = seq.sel;
  assign set_val = seq.val;

  always_comb begin
    next_pc   = inc;
    to_decode = 1'b0;
    set_en    = 1'b0;
    case (seq.op)
      SQ_NEXT:  next_pc = inc;
      SQ_JUMP:  next_pc = tgt;
      SQ_JFLAG: if (flags_in[seq.sel] == seq.val) next_pc = tgt;
      SQ_SETF:  set_en = 1'b1;
      default:  begin
        to_decode = 1'b1;
        next_pc   = '0;
      end
    endcase
  end
endmodule

// File: rtl/useq_flags.sv
module useq_flags
  import useq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [NFLAG-1:0] load_val,
  input  logic             set_en,
  input  logic [1:0]       set_sel,
  input  logic             set_val,
  output logic [NFLAG-1:0] flags
);
  logic [NFLAG-1:0] flags_nxt;

  always_comb begin
    flags_nxt = load ? load_val : flags;
    if (set_en) flags_nxt[set_sel] = set_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags <= '0;
    else        flags <= flags_nxt;
  end

  // R8: outside a decode load, at most one flag moves per cycle
  a_r8_single_flag_write: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $countones(flags ^ $past(flags)) <= 1);

  // R8: a set writes the requested value into the selected flag
  a_r8_set_value: assert property (@(posedge clk) disable iff (!rst_n)
    (set_en && !load) |=> flags[$past(set_sel)] == $past(set_val));
endmodule

// File: rtl/microseq_top.sv
module microseq_top
  import useq_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [15:0]       iq_word,
  input  logic              iq_valid,
  output logic              iq_ready,
  output logic [23:0]       uop_data,
  output logic              uop_valid,
  input  logic              uop_ready,
  output logic [ADDR_W-1:0] uaddr,
  output logic [3:0]        flags
);
  st_e               state;
  logic [ADDR_W-1:0] pc;
  logic              in_dec;
  logic              beat;

  logic [UI_W-1:0]   sd_uinstr, cs_uinstr;
  seq_t              sd_seq, cs_seq, cur_seq;
  logic [NFLAG-1:0]  sd_flags, test_flags;
  logic [ADDR_W-1:0] base_pc, next_pc;
  logic              to_decode, set_en, set_val;
  logic [1:0]        set_sel;

  useq_start_dec u_start (
    .word(iq_word), .uinstr(sd_uinstr), .seq(sd_seq), .init_flags(sd_flags)
  );

  useq_cstore #(.ADDR_W(ADDR_W)) u_cstore (
    .addr(pc), .uinstr(cs_uinstr), .seq(cs_seq)
  );

  assign in_dec     = (state == ST_DECODE);
  assign cur_seq    = in_dec ? sd_seq : cs_seq;
  assign base_pc    = in_dec ? '0 : pc;
  assign test_flags = in_dec ? sd_flags : flags;

  useq_next_addr #(.ADDR_W(ADDR_W)) u_next (
    .seq(cur_seq), .pc(base_pc), .flags_in(test_flags),
    .next_pc(next_pc), .to_decode(to_decode),
    .set_en(set_en), .set_sel(set_sel), .set_val(set_val)
  );

  assign uop_valid = in_dec ? iq_valid : 1'b1;
  assign uop_data  = in_dec ? sd_uinstr : cs_uinstr;
  assign iq_ready  = in_dec && uop_ready;
  assign beat      = uop_valid && uop_ready;
  assign uaddr     = pc;

  useq_flags u_flags (
    .clk(clk), .rst_n(rst_n),
    .load(beat && in_dec), .load_val(sd_flags),
    .set_en(beat && set_en), .set_sel(set_sel), .set_val(set_val),
    .flags(flags)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_DECODE;
      pc    <= '0;
    end else if (beat) begin
      if (to_decode) begin
        state <= ST_DECODE;
        pc    <= '0;
      end else begin
        state <= ST_RUN;
        pc    <= next_pc;
      end
    end
  end

  // R2: empty queue in decode issues nothing
  a_r2_idle_no_uop: assert property (@(posedge clk) disable iff (!rst_n)
    (in_dec && !iq_valid) |-> !uop_valid);

  // R3: a pop coincides with an accepted starting microinstruction
  a_r3_pop_with_beat: assert property (@(posedge clk) disable iff (!rst_n)
    (iq_valid && iq_ready) |-> (beat && uop_data[23:20] == 4'hA));

  // R10: a stalled beat is held unchanged
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (uop_valid && !uop_ready) |=> (uop_valid && $stable(uop_data) && $stable(uaddr)));

  // R9: an accepted end lands back at address zero
  a_r9_end_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (beat && to_decode) |=> (uaddr == '0));

  // R12: control store beats carry their own address
  a_r12_addr_tag: assert property (@(posedge clk) disable iff (!rst_n)
    !in_dec |-> (uop_data[ADDR_W-1:0] == uaddr && uop_data[23:16] == 8'hC0));
endmodule

// File: tb/microseq_top_tb_top.sv
module microseq_top_tb_top;
  localparam int ADDR_W = 6;
  localparam int NV = 8;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [15:0]       iq_word = '0;
  logic              iq_valid = 1'b0;
  logic              iq_ready;
  logic [23:0]       uop_data;
  logic              uop_valid;
  logic              uop_ready = 1'b1;
  logic [ADDR_W-1:0] uaddr;
  logic [3:0]        flags;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  microseq_top #(.ADDR_W(ADDR_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .iq_word(iq_word), .iq_valid(iq_valid),
    .iq_ready(iq_ready), .uop_data(uop_data), .uop_valid(uop_valid),
    .uop_ready(uop_ready), .uaddr(uaddr), .flags(flags)
  );

  // vectors: word, beat count, beats (beat0 in low bits), final flags
  localparam logic [15:0] V_WORD [NV] = '{16'h0123, 16'h1005, 16'h2009, 16'h2000,
                                          16'h2002, 16'h3000, 16'hF00F, 16'h4003};
  localparam int V_CNT [NV] = '{1, 3, 3, 5, 5, 5, 1, 1};
  localparam logic [119:0] V_EXP [NV] = '{
    {96'h0, 24'hA00123},
    {48'h0, 24'hC00011, 24'hC00010, 24'hA11005},
    {48'h0, 24'hC00021, 24'hC00020, 24'hA22009},
    {24'hC00011, 24'hC00018, 24'hC00002, 24'hC00001, 24'hA22000},
    {24'hC00019, 24'hC00018, 24'hC00002, 24'hC00001, 24'hA22002},
    {24'hC00011, 24'hC00018, 24'hC00002, 24'hC00001, 24'hA33000},
    {96'h0, 24'hAFF00F},
    {96'h0, 24'hA44003}
  };
  localparam logic [3:0] V_FLG [NV] = '{4'h0, 4'h5, 4'h1, 4'h4, 4'h6, 4'h4, 4'hF, 4'h3};
  localparam string V_TAG [NV] = '{"R4/R9", "R6", "R7/R8", "R7/R8/R11",
                                   "R7/R8", "R11/R6", "R4", "R5"};

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // one macroinstruction; stall_at >= 0 holds uop_ready low at that beat
  task automatic run_vec(int i, int stall_at);
    logic [23:0] e;
    iq_word   = V_WORD[i];
    iq_valid  = 1'b1;
    uop_ready = 1'b1;
    for (int n = 0; n < V_CNT[i]; n++) begin
      e = V_EXP[i][n*24 +: 24];
      if (n == stall_at) begin
        uop_ready = 1'b0;
        for (int k = 0; k < 3; k++) begin
          @(posedge clk); #1;
          chk("R10 held data", 32'(uop_data), 32'(e));
          chk("R10 held valid", 32'(uop_valid), 32'd1);
          chk("R3 no pop while stalled", 32'(iq_ready), 32'd0);
        end
        uop_ready = 1'b1;
      end
      #1;
      chk({V_TAG[i], " beat data"}, 32'(uop_data), 32'(e));
      chk({V_TAG[i], " beat valid"}, 32'(uop_valid), 32'd1);
      if (n == 0) chk("R3 pop at decode", 32'(iq_ready), 32'd1);
      else begin
        chk("R3 no pop in run", 32'(iq_ready), 32'd0);
        chk("R12 uaddr", 32'(uaddr), 32'(e[ADDR_W-1:0]));
      end
      @(posedge clk); #1;
      iq_valid = 1'b0;
      @(negedge clk);
    end
    #1;
    chk({V_TAG[i], " beat count"}, 32'(uop_valid), 32'd0);
    chk("R9 back at decode", 32'(iq_ready), 32'd1);
    chk("R9 uaddr zero", 32'(uaddr), 32'd0);
    chk({V_TAG[i], " flags"}, 32'(flags), 32'(V_FLG[i]));
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    chk("R1 flags", 32'(flags), 32'd0);
    chk("R1 uaddr", 32'(uaddr), 32'd0);
    chk("R1 uop_valid", 32'(uop_valid), 32'd0);
    chk("R1 iq_ready", 32'(iq_ready), 32'd1);
    @(negedge clk);

    for (int i = 0; i < NV; i++) run_vec(i, -1);

    // R2 empty queue stall after flags were left at 3
    for (int k = 0; k < 5; k++) begin
      @(posedge clk); #1;
      chk("R2 no uop", 32'(uop_valid), 32'd0);
      chk("R2 flags stable", 32'(flags), 32'h3);
      chk("R2 uaddr stable", 32'(uaddr), 32'd0);
    end
    @(negedge clk);

    // R3/R10 decode with consumer stalled: no pop, flags untouched
    iq_word = 16'h1005; iq_valid = 1'b1; uop_ready = 1'b0;
    for (int k = 0; k < 3; k++) begin
      @(posedge clk); #1;
      chk("R3 no pop without uop_ready", 32'(iq_ready), 32'd0);
      chk("R10 decode beat held", 32'(uop_data), 32'hA11005);
      chk("R10 flags held", 32'(flags), 32'h3);
    end
    @(negedge clk);
    run_vec(1, -1);

    // R10 stall inside the control store walk
    run_vec(4, 2);
    run_vec(3, 3);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule